// File: doc/BRIEF.md
# Receive FIFO Read Aligner

This block sits between a receive byte FIFO and a 32-bit host read port. For every packet it takes from the byte stream, it first emits a programmable number of zero bytes, then the packet bytes, then zero pad bytes until the running byte position of the packet transfer reaches a programmable alignment boundary. The bytes are packed little-endian into 32-bit words, and the host unloads them one word per read strobe.

A single configuration word holds three fields. The first sets the leading offset. The second sets the end alignment. The third is a word count for a host DMA transfer. When that count is non-zero, the block counts the words the host reads and raises a sticky interrupt once the programmed number has been read. One count can span several packets, so a driver can queue a batch of reads and wait for one interrupt. Offset and alignment are sampled when a packet begins, so a configuration write during a packet does not change it.

The byte source presents one byte per cycle with `byteValid` and holds the packet length on `pktLen` while it presents the first byte of each packet. A byte is consumed in each cycle in which `byteReady` is high.

Top module: `rx_read_aligner`

## Requirements
- R1: After reset, `rdValid`, `irq` and `byteReady` are 0.
- R2: Configuration bits 4:0 give N. Each packet is preceded in the read stream by N zero bytes, so the first packet byte sits at byte position N.
- R3: Bytes are packed into words with the earliest byte in bits 7:0 and the fourth byte in bits 31:24. All offset and pad bytes are zero.
- R4: Configuration bits 31:30 select the end alignment: 0 gives 4 bytes, 1 gives 16, 2 gives 32, and 3 (illegal) is treated as 4. After the last packet byte, zero bytes are added until offset plus length plus pad is a multiple of the alignment. No pad is added when the total is already a multiple.
- R5: Offset and alignment are taken from the configuration at the start of each packet. A configuration write made while a packet is in progress only affects later packets.
- R6: `rdData`/`rdValid` show the oldest unread word and hold it until a cycle in which `rdStrobe` and `rdValid` are both high, which consumes it. `rdStrobe` while `rdValid` is 0 has no effect.
- R7: A configuration write loads the count from bits 27:16. Each consumed word decrements a non-zero count. `irq` rises in the cycle after the consumed word that brings the count to zero, even when the words come from several packets.
- R8: A count of zero never raises `irq`.
- R9: `irq` stays set until `irqClr` is high on a clock edge. If a count completes on the same edge as `irqClr`, `irq` ends up set.
- R10: `byteReady` is only high while `byteValid` is high. Packet length (at least 1) is sampled with the first byte of each packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 32 | Configuration word: offset [4:0], count [27:16], alignment [31:30] |
| byteValid | input | 1 | Source byte present |
| byteData | input | 8 | Source byte |
| pktLen | input | LEN_W (11) | Packet length in bytes, valid with the first byte |
| byteReady | output | 1 | Source byte consumed this cycle |
| rdStrobe | input | 1 | Host read strobe |
| rdData | output | 32 | Oldest unread word |
| rdValid | output | 1 | `rdData` holds a word |
| irqClr | input | 1 | Clears the interrupt |
| irq | output | 1 | Sticky DMA-done interrupt |

## Verification
Two events can meet in one cycle. The first is the read that completes the DMA count. The second is a host clear of an interrupt that is still set from an earlier count. The bench provokes this by leaving the interrupt set, programming a short count, and driving `irqClr` on exactly the strobe that takes the final word. It then expects `irq` to remain 1, whereas clear-priority logic would drop it to 0. A separate check confirms that a clear on its own does lower the interrupt.

// File: rtl/rx_read_aligner_pkg.sv
package rx_read_aligner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFFS = 2'd1,
    ST_DATA = 2'd2,
    ST_PAD  = 2'd3
  } alignStateT;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic emit;    // push one byte into the packer
    logic padSel;  // push a zero byte instead of byteData
  } stepCmdT;

  // Low-bit mask of the alignment boundary; code 3 falls back to 4 bytes
  function automatic logic [4:0] alignMask(input logic [1:0] code);
    case (code)
      2'd1:    alignMask = 5'd15;
      2'd2:    alignMask = 5'd31;
      default: alignMask = 5'd3;
    endcase
  endfunction

endpackage

// File: rtl/rx_read_aligner_ctrl.sv
module rx_read_aligner_ctrl
  import rx_read_aligner_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int OFS_W   = 5,
  parameter int CNT_W   = 12,
  parameter int CNT_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [31:0]       cfgData,
  input  logic              byteValid,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic              stepOk,
  input  logic              popFire,
  input  logic              irqClr,
  output stepCmdT           step,
  output logic              byteReady,
  output logic              irq
);

  localparam logic [31:0] USED_MASK =
      ((32'd1 << OFS_W) - 32'd1) | (((32'd1 << CNT_W) - 32'd1) << CNT_LSB) | 32'hC000_0000;

  logic [OFS_W-1:0] cfgOfs;
  logic [1:0]       cfgAlign;
  logic [CNT_W-1:0] dmaLeft;

  alignStateT       state;
  logic [4:0]       curMask;
  logic [OFS_W-1:0] ofsLeft;
  logic [LEN_W-1:0] lenLeft;
  logic [4:0]       pos;
  logic [4:0]       posNext;
  logic             irqSet;
  logic             unusedCfgBits;

  assign unusedCfgBits = ^(cfgData & ~USED_MASK);

  assign posNext   = pos + 5'd1;
  assign step.emit = stepOk && ((state == ST_OFFS) || (state == ST_PAD) ||
                                ((state == ST_DATA) && byteValid));
  assign step.padSel = (state != ST_DATA);
  assign byteReady   = stepOk && (state == ST_DATA) && byteValid;

  // Configuration holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOfs   <= '0;
      cfgAlign <= '0;
    end else if (cfgWe) begin
      cfgOfs   <= cfgData[OFS_W-1:0];
      cfgAlign <= cfgData[31:30];
    end
  end

  // Per-packet sequencer: offset, data, pad
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curMask <= 5'd3;
      ofsLeft <= '0;
      lenLeft <= '0;
      pos     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (byteValid) begin
          curMask <= alignMask(cfgAlign);
          ofsLeft <= cfgOfs;
          lenLeft <= pktLen;
          pos     <= '0;
          state   <= (cfgOfs != '0) ? ST_OFFS : ST_DATA;
        end
        ST_OFFS: if (step.emit) begin
          pos     <= posNext;
          ofsLeft <= ofsLeft - OFS_W'(1);
          if (ofsLeft == OFS_W'(1)) state <= ST_DATA;
        end
        ST_DATA: if (step.emit) begin
          pos     <= posNext;
          lenLeft <= lenLeft - LEN_W'(1);
          if (lenLeft == LEN_W'(1))
            state <= ((posNext & curMask) == 5'd0) ? ST_IDLE : ST_PAD;
        end
        default: if (step.emit) begin
          pos <= posNext;
          if ((posNext & curMask) == 5'd0) state <= ST_IDLE;
        end
      endcase
    end
  end

  // DMA word counter and sticky interrupt (set beats clear)
  assign irqSet = !cfgWe && popFire && (dmaLeft == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaLeft <= '0;
      irq     <= 1'b0;
    end else begin
      if (cfgWe)
        dmaLeft <= cfgData[CNT_LSB +: CNT_W];
      else if (popFire && (dmaLeft != '0))
        dmaLeft <= dmaLeft - CNT_W'(1);
      if (irqSet)
        irq <= 1'b1;
      else if (irqClr)
        irq <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_read_aligner_dp.sv
module rx_read_aligner_dp
  import rx_read_aligner_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  stepCmdT      step,
  input  logic [7:0]   byteData,
  input  logic         rdStrobe,
  output logic [31:0]  rdData,
  output logic         rdValid,
  output logic         stepOk,
  output logic         popFire
);

  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane;
  logic [7:0]        asmLane [LANES-1];
  logic [7:0]        byteIn;
  logic [31:0]       outWord;
  logic              outFull;
  logic [31:0]       fullWord;

  assign byteIn  = step.padSel ? 8'h00 : byteData;
  assign stepOk  = !((lane == LAST) && outFull);
  assign popFire = rdStrobe && outFull;
  assign rdData  = outWord;
  assign rdValid = outFull;

  // Lower lanes collect bytes until the top lane completes a word
  for (genvar g = 0; g < LANES - 1; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        asmLane[g] <= '0;
      else if (step.emit && (lane == LANE_W'(g)))
        asmLane[g] <= byteIn;
    end
    assign fullWord[g*8 +: 8] = asmLane[g];
  end
  assign fullWord[31:24] = byteIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lane    <= '0;
      outWord <= '0;
      outFull <= 1'b0;
    end else begin
      if (popFire) outFull <= 1'b0;
      if (step.emit) begin
        lane <= lane + LANE_W'(1);
        if (lane == LAST) begin
          outWord <= fullWord;
          outFull <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_read_aligner.sv
module rx_read_aligner
  import rx_read_aligner_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int OFS_W = 5,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [31:0]      cfgData,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic [LEN_W-1:0] pktLen,
  output logic             byteReady,
  input  logic             rdStrobe,
  output logic [31:0]      rdData,
  output logic             rdValid,
  input  logic             irqClr,
  output logic             irq
);

  stepCmdT step;
  logic    stepOk;
  logic    popFire;

  rx_read_aligner_ctrl #(
    .LEN_W(LEN_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .CNT_LSB(16)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .byteValid(byteValid), .pktLen(pktLen), .stepOk(stepOk),
    .popFire(popFire), .irqClr(irqClr), .step(step),
    .byteReady(byteReady), .irq(irq)
  );

  rx_read_aligner_dp #(.LANES(4)) u_dp (
    .clk(clk), .rstN(rstN), .step(step), .byteData(byteData),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdValid(rdValid),
    .stepOk(stepOk), .popFire(popFire)
  );

endmodule

// File: rtl/rx_read_aligner_chk.sv
module rx_read_aligner_chk (
  input logic        clk,
  input logic        rstN,
  input logic        byteValid,
  input logic        byteReady,
  input logic        rdStrobe,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        irqClr,
  input logic        irq
);

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdStrobe) |=> (rdValid && $stable(rdData)));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  assert_irq_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !(rdStrobe && rdValid)) |=> !irq);

  assert_irq_after_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(rdStrobe && rdValid));

  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> byteValid);

endmodule

bind rx_read_aligner rx_read_aligner_chk u_chk (.*);

// File: tb/rx_read_aligner_bench.sv
module rx_read_aligner_bench;

  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [31:0]      cfgData = '0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = '0;
  logic [LEN_W-1:0] pktLen = '0;
  logic             byteReady;
  logic             rdStrobe = 1'b0;
  logic [31:0]      rdData;
  logic             rdValid;
  logic             irqClr = 1'b0;
  logic             irq;

  always #4 clk = ~clk;

  rx_read_aligner #(.LEN_W(LEN_W)) u_rx_read_aligner (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .byteValid(byteValid), .byteData(byteData), .pktLen(pktLen),
    .byteReady(byteReady), .rdStrobe(rdStrobe), .rdData(rdData),
    .rdValid(rdValid), .irqClr(irqClr), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int popCount = 0;
  int pushCount = 0;
  bit rdOn = 1'b1;
  bit clrNow = 1'b0;
  bit collArm = 1'b0;
  int collAt = 0;
  bit finished = 1'b0;

  logic [7:0]  bQ[$];
  int          lQ[$];
  logic [31:0] expQ[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input int ofs, input int cnt, input int algn);
    @(negedge clk);
    cfgWe   = 1'b1;
    cfgData = (32'(algn) << 30) | (32'(cnt) << 16) | 32'(ofs);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Driver: queue source bytes and the expected words for one packet
  task automatic sendPkt(input int len, input int ofs, input int algn, input int seed);
    logic [7:0] ex[$];
    int bnd;
    bnd = (algn == 1) ? 16 : (algn == 2) ? 32 : 4;
    for (int i = 0; i < ofs; i++) ex.push_back(8'h00);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((seed * 7 + i * 13 + 1) & 255);
      ex.push_back(b);
      bQ.push_back(b);
    end
    while ((ex.size() % bnd) != 0) ex.push_back(8'h00);
    for (int k = 0; k < ex.size() / 4; k++) begin
      expQ.push_back({ex[4*k+3], ex[4*k+2], ex[4*k+1], ex[4*k]});
      pushCount++;
    end
    lQ.push_back(len);
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || bQ.size() != 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Byte source
  initial begin
    int left = 0;
    int gap = 0;
    forever begin
      @(negedge clk);
      gap++;
      if (bQ.size() > 0 && lQ.size() > 0 && (gap % 7) != 6) begin
        if (left == 0) left = lQ[0];
        byteValid = 1'b1;
        byteData  = bQ[0];
        pktLen    = LEN_W'(lQ[0]);
        #1;
        if (byteReady) begin
          void'(bQ.pop_front());
          left--;
          if (left == 0) void'(lQ.pop_front());
        end
      end else begin
        byteValid = 1'b0;
      end
    end
  end

  // Host reader and scoreboard monitor
  initial begin
    int rc = 0;
    forever begin
      bit s;
      bit hit;
      @(negedge clk);
      s = rdOn && ((rc % 3) != 2);
      rc++;
      hit = 1'b0;
      if (s && rdValid && rstN) begin
        popCount++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected word", rdData, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk(rdData == e, "R2 R3 R4 R5 word", rdData, e);
        end
        hit = collArm && (popCount == collAt);
      end
      rdStrobe = s;
      irqClr = clrNow || hit;
      if (hit) collArm = 1'b0;
      clrNow = 1'b0;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(byteReady == 1'b0, "R1 byteReady after reset", byteReady, 0);

    // Offset 18, 32-byte alignment, count 32: 18+89+21 = 128 bytes
    writeCfg(18, 32, 2);
    base = popCount;
    sendPkt(89, 18, 2, 1);
    while (popCount < base + 31) @(negedge clk);
    chk(irq == 1'b0, "R7 irq before final word", irq, 0);
    drain();
    chk(popCount - base == 32, "R4 example word count", popCount - base, 32);
    chk(irq == 1'b1, "R7 irq after count", irq, 1);

    clrNow = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 clear lowers irq", irq, 0);

    // Count spanning two packets
    writeCfg(0, 4, 0);
    sendPkt(5, 0, 0, 2);
    drain();
    chk(irq == 1'b0, "R7 irq held across packets", irq, 0);
    chk(rdValid == 1'b0, "R6 empty after drain", rdValid, 0);
    sendPkt(8, 0, 0, 3);
    drain();
    chk(irq == 1'b1, "R7 irq after second packet", irq, 1);

    // Completion coinciding with clear: set wins (irq is already 1)
    writeCfg(0, 2, 3);
    collAt  = popCount + 2;
    collArm = 1'b1;
    sendPkt(6, 0, 3, 4);
    drain();
    chk(collArm == 1'b0, "R9 collision provoked", collArm, 0);
    chk(irq == 1'b1, "R9 set beats clear", irq, 1);
    clrNow = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 clear after collision", irq, 0);

    // 16-byte alignment, count zero
    writeCfg(3, 0, 1);
    base = popCount;
    sendPkt(20, 3, 1, 5);
    drain();
    chk(popCount - base == 8, "R4 16-byte pad", popCount - base, 8);
    chk(irq == 1'b0, "R8 zero count no irq", irq, 0);

    // Configuration change during a packet
    writeCfg(7, 0, 2);
    sendPkt(40, 7, 2, 6);
    while (bQ.size() > 30) @(negedge clk);
    writeCfg(1, 0, 0);
    sendPkt(10, 1, 0, 7);
    drain();
    chk(expQ.size() == 0, "R5 mid-packet config", expQ.size(), 0);

    // Boundaries: max offset, exact fits
    writeCfg(31, 0, 2);
    base = popCount;
    sendPkt(1, 31, 2, 8);
    drain();
    chk(popCount - base == 8, "R2 offset 31 no pad", popCount - base, 8);
    writeCfg(0, 0, 2);
    base = popCount;
    sendPkt(32, 0, 2, 9);
    drain();
    chk(popCount - base == 8, "R4 exact boundary", popCount - base, 8);

    // Held word while host pauses
    writeCfg(2, 0, 0);
    rdOn = 1'b0;
    sendPkt(6, 2, 0, 10);
    repeat (30) @(negedge clk);
    chk(rdValid == 1'b1, "R6 word waits", rdValid, 1);
    chk(rdData == expQ[0], "R6 held word value", rdData, expQ[0]);
    rdOn = 1'b1;
    drain();
    chk(popCount == pushCount, "R6 R10 total words", popCount, pushCount);
    finish();
  end

endmodule